// File: doc/BRIEF.md
# Synchronous Exception Priority Arbiter

This block sits beside the execute stage of an in-order core and decides which synchronous interrupt, if any, a single instruction raises. Each cycle the stage may present one instruction together with a vector of raised exception conditions and a matching vector of interrupt-type enable bits. One cycle after it accepts the instruction, the arbiter presents the single winning cause with a one-cycle valid strobe. It also presents a record mask that tells the status logic which exception flags may be latched for that instruction.

A side path keeps two sticky imprecise conditions: a floating-point enabled exception and a debug event. These are reported only when a synchronizing event arrives and their enables are set. When both can go, the floating-point program interrupt is issued first. The debug interrupt is held until the consumer acknowledges the first, so only one cause is ever outstanding. While that drain is in progress, new instructions are held off through a ready output. Machine-check conditions do not enter this block.

Top module: `exc_prio_arb`

## Requirements
- R1: Exception bit positions are fixed, with bit 0 highest priority: bit 0 instruction-address-compare debug, bit 1 instruction TLB miss, bit 2 instruction storage execute-access violation, bit 3 illegal-instruction program. The winner is the lowest-index bit that is both raised and enabled.
- R2: An instruction is accepted when `instr_valid_i` and `ready_o` are both high. If at least one raised bit is enabled, `valid_o` is high in the next cycle for exactly one cycle, and `cause_o` = winning index + 1. Otherwise `valid_o` stays 0. `cause_o` is 0 whenever `valid_o` is 0.
- R3: A raised exception whose enable bit is 0 changes neither the selected cause nor any other bit of the record mask.
- R4: In the cycle after acceptance, `record_o` bit i is 1 exactly when bit i is raised and no lower-index bit is both raised and enabled, whatever bit i's own enable. In every other cycle `record_o` is 0.
- R5: A pulse on `fp_exc_i` or `dbg_imp_i` sets a sticky pending flag. No interrupt is reported for it until `sync_i` is high while the matching enable (`fp_en_i` or `dbg_en_i`) is high.
- R6: If, at a synchronizing cycle, exactly one pending condition is enabled, the next cycle shows `valid_o`=1 with cause 5 (floating-point) or cause 1 (debug), and that flag is cleared. A pending condition whose enable is low stays pending for a later synchronizing event.
- R7: If both pending conditions are enabled at the synchronizing cycle, cause 5 is issued in the next cycle. Cause 1 is issued in the cycle after the first cycle in which `ack_i` is high, and `valid_o` stays 0 before that.
- R8: `ready_o` is 0 in any cycle where a drain starts, and from then until the held debug interrupt is issued. An instruction offered while `ready_o` is 0 is not accepted: it produces no valid and a zero record mask.
- R9: Reset (`rst_ni` low) clears both pending flags and forces `valid_o`=0, `cause_o`=0 and `record_o`=0, with `ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction present in execute |
| raw_exc_i | input | 4 | Raised exception flags, bit 0 highest priority |
| type_en_i | input | 4 | Interrupt-type enable per exception bit |
| fp_exc_i | input | 1 | Imprecise floating-point enabled exception reported |
| dbg_imp_i | input | 1 | Imprecise debug event reported |
| fp_en_i | input | 1 | Floating-point enabled interrupt type enable |
| dbg_en_i | input | 1 | Debug interrupt type enable |
| sync_i | input | 1 | Synchronizing event |
| ack_i | input | 1 | Consumer acknowledges the presented interrupt |
| ready_o | output | 1 | Instruction may be accepted this cycle |
| valid_o | output | 1 | One-cycle strobe for cause_o |
| cause_o | output | 3 | 0 none, 1 debug, 2 TLB miss, 3 storage, 4 illegal, 5 floating-point |
| record_o | output | 4 | Status bits allowed to latch for the accepted instruction |

## Verification
The checker assumes that `ack_i` is raised only in response to a presented interrupt. It also assumes that no second synchronizing event arrives in the cycle in which a floating-point interrupt is presented, because its tracking of the held debug interrupt keys on that cycle. The directed stimulus raises `ack_i` only after the first imprecise interrupt has been observed. It keeps `sync_i` to single isolated pulses and offers instructions during a drain only to confirm that they are refused.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int unsigned N_PREC  = 4;
  localparam int unsigned CAUSE_W = $clog2(N_PREC + 2);

  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t CAUSE_NONE = cause_t'(0);
  localparam cause_t CAUSE_DBG  = cause_t'(1);
  localparam cause_t CAUSE_FP   = cause_t'(N_PREC + 1);

  typedef enum logic {
    DR_IDLE = 1'b0,
    DR_WAIT = 1'b1
  } drain_st_e;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] sel_o,
  output logic [N-1:0] rec_o,
  output logic         hit_o
);
  // blk[i]: an enabled exception above bit i is raised
  logic [N:0] blk;
  assign blk[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign blk[i+1]  = blk[i] | (raw_i[i] & en_i[i]);
    assign sel_o[i]  = raw_i[i] & en_i[i] & ~blk[i];
    assign rec_o[i]  = raw_i[i] & ~blk[i];
  end

  assign hit_o = blk[N];
endmodule

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
  import exc_arb_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] sel_i,
  output cause_t       cause_o
);
  always_comb begin
    cause_o = CAUSE_NONE;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) cause_o = cause_o | cause_t'(i + 1);
    end
  end
endmodule

// File: rtl/imp_drain.sv
module imp_drain
  import exc_arb_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   fp_set_i,
  input  logic   dbg_set_i,
  input  logic   fp_en_i,
  input  logic   dbg_en_i,
  input  logic   sync_i,
  input  logic   ack_i,
  output logic   start_o,
  output logic   busy_o,
  output logic   issue_o,
  output cause_t issue_cause_o
);
  drain_st_e st_q, st_d;
  logic pend_fp_q, pend_dbg_q;
  logic fp_go, dbg_go, take_fp, take_dbg;

  assign fp_go   = pend_fp_q & fp_en_i;
  assign dbg_go  = pend_dbg_q & dbg_en_i;
  assign start_o = (st_q == DR_IDLE) & sync_i & (fp_go | dbg_go);
  assign busy_o  = (st_q == DR_WAIT);

  assign take_fp  = start_o & fp_go;
  assign take_dbg = start_o & dbg_go;

  always_comb begin
    st_d          = st_q;
    issue_o       = 1'b0;
    issue_cause_o = CAUSE_NONE;
    if (st_q == DR_IDLE) begin
      if (start_o) begin
        issue_o       = 1'b1;
        issue_cause_o = fp_go ? CAUSE_FP : CAUSE_DBG;
        if (fp_go && dbg_go) st_d = DR_WAIT;
      end
    end else if (ack_i) begin
      // held debug goes out after the first is acknowledged
      issue_o       = 1'b1;
      issue_cause_o = CAUSE_DBG;
      st_d          = DR_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= DR_IDLE;
      pend_fp_q  <= 1'b0;
      pend_dbg_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      pend_fp_q  <= (pend_fp_q & ~take_fp) | fp_set_i;
      pend_dbg_q <= (pend_dbg_q & ~take_dbg) | dbg_set_i;
    end
  end
endmodule

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_arb_pkg::*;
#(
  parameter int unsigned NUM_EXC = exc_arb_pkg::N_PREC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [NUM_EXC-1:0] raw_exc_i,
  input  logic [NUM_EXC-1:0] type_en_i,
  input  logic               fp_exc_i,
  input  logic               dbg_imp_i,
  input  logic               fp_en_i,
  input  logic               dbg_en_i,
  input  logic               sync_i,
  input  logic               ack_i,
  output logic               ready_o,
  output logic               valid_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [NUM_EXC-1:0] record_o
);
  logic [NUM_EXC-1:0] sel, rec, record_q;
  logic               hit, accept;
  logic               dr_start, dr_busy, dr_issue;
  cause_t             p_cause, dr_cause, cause_q;
  logic               valid_q;

  exc_prio_sel #(.N(NUM_EXC)) u_sel (
    .raw_i (raw_exc_i),
    .en_i  (type_en_i),
    .sel_o (sel),
    .rec_o (rec),
    .hit_o (hit)
  );

  exc_cause_enc #(.N(NUM_EXC)) u_enc (
    .sel_i   (sel),
    .cause_o (p_cause)
  );

  imp_drain u_drain (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fp_set_i      (fp_exc_i),
    .dbg_set_i     (dbg_imp_i),
    .fp_en_i       (fp_en_i),
    .dbg_en_i      (dbg_en_i),
    .sync_i        (sync_i),
    .ack_i         (ack_i),
    .start_o       (dr_start),
    .busy_o        (dr_busy),
    .issue_o       (dr_issue),
    .issue_cause_o (dr_cause)
  );

  assign ready_o = ~dr_busy & ~dr_start;
  assign accept  = instr_valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      cause_q  <= CAUSE_NONE;
      record_q <= '0;
    end else begin
      valid_q  <= dr_issue | (accept & hit);
      cause_q  <= dr_issue ? dr_cause : (accept ? p_cause : CAUSE_NONE);
      record_q <= accept ? rec : '0;
    end
  end

  assign valid_o  = valid_q;
  assign cause_o  = cause_q;
  assign record_o = record_q;
endmodule

// File: rtl/exc_prio_arb_chk.sv
module exc_prio_arb_chk
  import exc_arb_pkg::*;
#(
  parameter int unsigned NUM_EXC = exc_arb_pkg::N_PREC
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_i,
  input logic               ack_i,
  input logic               ready_o,
  input logic               valid_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [NUM_EXC-1:0] record_o
);
  logic held_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= 1'b0;
    else if (ack_i) held_q <= 1'b0;
    else if (valid_o && cause_o == CAUSE_FP && !ready_o && !sync_i) held_q <= 1'b1;
  end

  AST_NO_CAUSE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> cause_o == CAUSE_NONE); // R2

  AST_CAUSE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cause_o != CAUSE_NONE && cause_o <= CAUSE_FP)); // R2

  AST_STALL_NO_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> record_o == '0); // R8

  AST_DBG_WAITS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> !valid_o); // R7

  for (genvar k = 0; k < NUM_EXC; k++) begin : g_rec
    AST_WINNER_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && cause_o == cause_t'(k + 1) && record_o != '0)
        |-> (record_o[k] && (record_o >> (k + 1)) == '0)); // R4
  end
endmodule

bind exc_prio_arb exc_prio_arb_chk #(.NUM_EXC(NUM_EXC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sync_i   (sync_i),
  .ack_i    (ack_i),
  .ready_o  (ready_o),
  .valid_o  (valid_o),
  .cause_o  (cause_o),
  .record_o (record_o)
);

// File: tb/exc_prio_arb_tb.sv
module exc_prio_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0;
  logic [3:0] raw = '0, en = '0;
  logic       fp_exc = 1'b0, dbg_imp = 1'b0, fp_en = 1'b0, dbg_en = 1'b0;
  logic       sync = 1'b0, ack = 1'b0;
  logic       ready, valid;
  logic [2:0] cause;
  logic [3:0] record;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_prio_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid),
    .raw_exc_i(raw), .type_en_i(en), .fp_exc_i(fp_exc), .dbg_imp_i(dbg_imp),
    .fp_en_i(fp_en), .dbg_en_i(dbg_en), .sync_i(sync), .ack_i(ack),
    .ready_o(ready), .valid_o(valid), .cause_o(cause), .record_o(record)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int m_cause(input logic [3:0] r, input logic [3:0] e);
    for (int i = 0; i < 4; i++) if (r[i] && e[i]) return i + 1;
    return 0;
  endfunction

  function automatic logic [3:0] m_rec(input logic [3:0] r, input logic [3:0] e);
    logic [3:0] m = '0;
    for (int i = 0; i < 4; i++) begin
      m[i] = r[i];
      if (r[i] && e[i]) return m;
    end
    return m;
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic t_reset();
    chk("R9 valid", valid, 0); chk("R9 cause", cause, 0);
    chk("R9 record", record, 0); chk("R9 ready", ready, 1);
  endtask

  task automatic t_prec(input string req, input logic [3:0] r, input logic [3:0] e);
    instr_valid = 1'b1; raw = r; en = e;
    cyc();
    instr_valid = 1'b0; raw = '0; en = '0;
    chk({req, " valid"}, valid, m_cause(r, e) != 0);
    chk({req, " cause"}, cause, m_cause(r, e));
    chk({req, " record"}, record, m_rec(r, e));
    cyc();
    chk({req, " pulse"}, valid, 0);
    chk({req, " record clear"}, record, 0);
  endtask

  task automatic t_imp_single();
    fp_exc = 1'b1; dbg_imp = 1'b1; cyc(); fp_exc = 1'b0; dbg_imp = 1'b0;
    fp_en = 1'b1; dbg_en = 1'b1;
    cyc(); cyc();
    chk("R5 no report before sync", valid, 0);
    dbg_en = 1'b0; sync = 1'b1; #1;
    chk("R8 ready low at drain start", ready, 0);
    cyc(); sync = 1'b0;
    chk("R6 fp only valid", valid, 1); chk("R6 fp only cause", cause, 5);
    chk("R6 ready back", ready, 1);
    cyc();
    chk("R6 single pulse", valid, 0);
    fp_en = 1'b0; dbg_en = 1'b1; sync = 1'b1;
    cyc(); sync = 1'b0;
    chk("R6 kept debug valid", valid, 1); chk("R6 kept debug cause", cause, 1);
    cyc();
    sync = 1'b1; fp_en = 1'b1; cyc(); sync = 1'b0;
    chk("R6 flags cleared", valid, 0);
    fp_en = 1'b0; dbg_en = 1'b0;
  endtask

  task automatic t_imp_both();
    fp_exc = 1'b1; dbg_imp = 1'b1; cyc(); fp_exc = 1'b0; dbg_imp = 1'b0;
    fp_en = 1'b1; dbg_en = 1'b1; sync = 1'b1;
    cyc(); sync = 1'b0;
    chk("R7 fp first valid", valid, 1); chk("R7 fp first cause", cause, 5);
    chk("R8 ready low held", ready, 0);
    instr_valid = 1'b1; raw = 4'b0001; en = 4'b1111;
    cyc();
    instr_valid = 1'b0; raw = '0; en = '0;
    chk("R8 stalled no valid", valid, 0); chk("R8 stalled no record", record, 0);
    cyc(); cyc();
    chk("R7 no debug before ack", valid, 0); chk("R8 ready still low", ready, 0);
    ack = 1'b1; cyc(); ack = 1'b0;
    chk("R7 debug after ack valid", valid, 1); chk("R7 debug after ack cause", cause, 1);
    chk("R8 ready after issue", ready, 1);
    cyc();
    chk("R7 debug pulse", valid, 0);
    fp_en = 1'b0; dbg_en = 1'b0;
  endtask

  task automatic t_reset_mid();
    fp_exc = 1'b1; cyc(); fp_exc = 1'b0;
    rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
    t_reset();
    fp_en = 1'b1; sync = 1'b1; cyc(); sync = 1'b0;
    chk("R9 pending cleared", valid, 0);
    fp_en = 1'b0;
  endtask

  initial begin
    cyc(); cyc();
    t_reset();
    rst_n = 1'b1;
    cyc();
    t_prec("R1 all raised", 4'b1111, 4'b1111);
    t_prec("R1 tlb wins", 4'b1110, 4'b1111);
    t_prec("R1 storage wins", 4'b1100, 4'b1111);
    t_prec("R2 none enabled", 4'b1000, 4'b0111);
    t_prec("R2 nothing raised", 4'b0000, 4'b1111);
    t_prec("R3 debug disabled", 4'b1111, 4'b1110);
    t_prec("R3 disabled above", 4'b1101, 4'b1010);
    t_prec("R3 reference", 4'b1000, 4'b1010);
    t_prec("R4 disabled below blocked", 4'b1010, 4'b0010);
    t_prec("R4 disabled kept", 4'b1100, 4'b1000);
    t_imp_single();
    t_imp_both();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule